// File: doc/BRIEF.md
# GPIO Input Debounce Bank with Shared Period Timers

This block cleans up the inputs of a 32-pin general-purpose I/O bank before the rest of the chip uses them. Each raw pin first passes a two-flop synchronizer. It then passes a per-pin filter that lets a new level through only after the level has stayed put for a programmed number of clock cycles. The cycle counts come from a small pool of three period timers, and every pin shares that pool. Each pin chooses timer 1, 2 or 3 with a 2-bit index. Index 0 turns the filter off, and the synchronized level then goes straight to the output.

The index of a pin is split across two bit-plane registers. One register holds the upper index bit of every pin, and the other holds the lower bit. In both, the bit position equals the pin number. Software programs the periods and the planes through a plain write port. A combinational read port returns the register chosen by the same address. When several pins use one timer, a new value in that timer's period register changes the filter length of all of them together.

Each pin runs a two-state machine. In `ST_STEADY` the output agrees with the input, and the counter is zero. In `ST_SETTLE` the input differs from the output, and the counter runs. The transitions are:
- T_ARM: `ST_STEADY` → `ST_SETTLE` on the first mismatch when the period is longer than one cycle.
- T_COMMIT: the output takes the new level when the count reaches the period. The machine ends in or stays in `ST_STEADY`.
- T_BOUNCE: `ST_SETTLE` → `ST_STEADY` when the input returns to the output level. The count is dropped.
- T_RESELECT: either state goes to `ST_STEADY` with a cleared count when a write changes the pin's index.
- T_BYPASS: index 0 holds the machine in `ST_STEADY`, and the stored level follows the input.

Top module: `gpio_debounce_bank`

## Requirements
- R1: Register map on `reg_addr`. Addresses 1, 2 and 3 are the 32-bit period registers of timers 1, 2 and 3. Address 4 is the upper-index-bit plane. Address 5 is the lower-index-bit plane. A write lands on the rising edge while `reg_wr` is high. `reg_rdata` shows the addressed register combinationally. Addresses 0, 6 and 7 read as zero, and writes to them change nothing.
- R2: The timer index of pin p is {plane4[p], plane5[p]}.
- R3: With index 0, `pin_filt[p]` equals `pin_raw[p]` delayed by exactly two rising edges.
- R4: With index 1 to 3 and that timer's period P ≥ 2, a new raw level that is held steady appears on `pin_filt[p]` exactly P+2 rising edges after it was applied.
- R5: A change of the synchronized level that lasts fewer cycles than P, followed by a return to the old level, leaves `pin_filt[p]` unchanged.
- R6: Pins that select the same timer filter with the same period. A write to that period register changes the latency of all of them.
- R7: A selected period of 0 or 1 gives a latency of 3 rising edges.
- R8: After reset both planes and all periods read 0, and every `pin_filt` bit equals its synchronized input. That input is 0 right after reset.
- R9: A write that changes a pin's index clears that pin's count. Counting restarts at the next edge, so the pin changes exactly P_new edges after the write edge.
- R10: A filtered pin that is not bypassed only ever changes to the level its synchronized input had one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pin_raw | input | 32 | Unsynchronized pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Addressed register contents |
| pin_filt | output | 32 | Debounced pin levels |

## Verification
On every cycle the assertions check four things. They check the register read-back and the zero reads. They check that bypassed pins follow the raw input two edges late. They check that a filtered pin only ever moves to its recently synchronized level, and that a zero period commits on the very next edge. The exact latency of each period, the rejection of short bounces, the effect of one period register on several pins, and the restart after a change of index depend on counted waits. Only the bench's timed scenarios can show those. The bench sweeps every pin in both directions under two index layouts and two sets of periods, and it computes each expected latency from the index planes it wrote.

// File: rtl/gdb_pkg.sv
package gdb_pkg;

    localparam int PIN_N  = 32;
    localparam int TMR_N  = 3;
    localparam int PER_W  = 32;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    typedef enum logic {
        ST_STEADY = 1'b0,
        ST_SETTLE = 1'b1
    } pin_state_e;

endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_in;
            stab_q <= meta_q;
        end
    end

    assign d_out = stab_q;
endmodule

// File: rtl/gdb_regs.sv
module gdb_regs #(
    parameter int PIN_N  = 32,
    parameter int TMR_N  = 3,
    parameter int PER_W  = 32,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [DATA_W-1:0]                 reg_wdata,
    output logic [DATA_W-1:0]                 reg_rdata,
    output logic [IDX_W-1:0][PIN_N-1:0]       sel_plane,
    output logic [TMR_N-1:0][PER_W-1:0]       tmr_per,
    output logic [PIN_N-1:0]                  resel
);
    // Timer t (0-based) sits at address t+1; index bit b sits at TMR_N+IDX_W-b.
    function automatic logic [ADDR_W-1:0] plane_adr(input int b);
        return ADDR_W'(TMR_N + IDX_W - b);
    endfunction

    // R1: period registers
    for (genvar t = 0; t < TMR_N; t++) begin : g_tmr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                tmr_per[t] <= '0;
            else if (reg_wr && reg_addr == ADDR_W'(t + 1))
                tmr_per[t] <= reg_wdata[PER_W-1:0];
        end
    end

    // R1, R2: index bit planes
    for (genvar b = 0; b < IDX_W; b++) begin : g_plane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sel_plane[b] <= '0;
            else if (reg_wr && reg_addr == plane_adr(b))
                sel_plane[b] <= reg_wdata[PIN_N-1:0];
        end
    end

    // R9: pins whose index bit flips on this write
    always_comb begin
        resel = '0;
        for (int b = 0; b < IDX_W; b++) begin
            if (reg_wr && reg_addr == plane_adr(b))
                resel = resel | (reg_wdata[PIN_N-1:0] ^ sel_plane[b]);
        end
    end

    // R1: read mux, unmapped addresses return zero
    always_comb begin
        reg_rdata = '0;
        for (int t = 0; t < TMR_N; t++) begin
            if (reg_addr == ADDR_W'(t + 1))
                reg_rdata = DATA_W'(tmr_per[t]);
        end
        for (int b = 0; b < IDX_W; b++) begin
            if (reg_addr == plane_adr(b))
                reg_rdata = DATA_W'(sel_plane[b]);
        end
    end
endmodule

// File: rtl/gdb_pin_fsm.sv
module gdb_pin_fsm
    import gdb_pkg::*;
#(
    parameter int PER_W = 32,
    parameter int TMR_N = 3,
    parameter int IDX_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sync_in,
    input  logic [IDX_W-1:0]            sel_idx,
    input  logic [TMR_N-1:0][PER_W-1:0] tmr_per,
    input  logic                        resel,
    output logic                        filt
);
    pin_state_e       st_q, st_d;
    logic [PER_W-1:0] cnt_q, cnt_d;
    logic             hold_q, hold_d;

    logic [PER_W-1:0] per;
    logic [PER_W:0]   cnt_inc;
    logic             bypass;
    logic             differ;
    logic             expire;

    always_comb begin
        per = '0;
        for (int t = 0; t < TMR_N; t++) begin
            if (sel_idx == IDX_W'(t + 1))
                per = tmr_per[t];
        end
        bypass  = (sel_idx == '0);
        differ  = (sync_in != hold_q);
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        expire  = (cnt_inc >= {1'b0, per});
    end

    // next state
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        hold_d = hold_q;
        if (bypass) begin
            // T_BYPASS (R3)
            st_d   = ST_STEADY;
            cnt_d  = '0;
            hold_d = sync_in;
        end else if (resel) begin
            // T_RESELECT (R9)
            st_d  = ST_STEADY;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_STEADY: begin
                    if (differ) begin
                        if (expire) begin
                            hold_d = sync_in;             // T_COMMIT (R7)
                        end else begin
                            st_d  = ST_SETTLE;            // T_ARM
                            cnt_d = cnt_inc[PER_W-1:0];
                        end
                    end
                end
                ST_SETTLE: begin
                    if (!differ) begin
                        st_d  = ST_STEADY;                // T_BOUNCE (R5)
                        cnt_d = '0;
                    end else if (expire) begin
                        st_d   = ST_STEADY;               // T_COMMIT (R4)
                        cnt_d  = '0;
                        hold_d = sync_in;
                    end else begin
                        cnt_d = cnt_inc[PER_W-1:0];
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_STEADY;
            cnt_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            hold_q <= hold_d;
        end
    end

    // outputs
    always_comb begin
        filt = bypass ? sync_in : hold_q;
    end
endmodule

// File: rtl/gpio_debounce_bank.sv
module gpio_debounce_bank #(
    parameter int PIN_N  = gdb_pkg::PIN_N,
    parameter int TMR_N  = gdb_pkg::TMR_N,
    parameter int PER_W  = gdb_pkg::PER_W,
    parameter int ADDR_W = gdb_pkg::ADDR_W,
    parameter int DATA_W = gdb_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_N-1:0]  pin_raw,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [PIN_N-1:0]  pin_filt
);
    localparam int IDX_W = $clog2(TMR_N + 1);

    logic [PIN_N-1:0]                sync_w;
    logic [IDX_W-1:0][PIN_N-1:0]     sel_plane;
    logic [TMR_N-1:0][PER_W-1:0]     tmr_per;
    logic [PIN_N-1:0]                resel;

    gdb_sync #(.W(PIN_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_raw),
        .d_out (sync_w)
    );

    gdb_regs #(
        .PIN_N (PIN_N), .TMR_N (TMR_N), .PER_W (PER_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sel_plane (sel_plane),
        .tmr_per   (tmr_per),
        .resel     (resel)
    );

    for (genvar p = 0; p < PIN_N; p++) begin : g_pin
        logic [IDX_W-1:0] idx;
        always_comb begin
            for (int b = 0; b < IDX_W; b++)
                idx[b] = sel_plane[b][p];
        end

        gdb_pin_fsm #(.PER_W(PER_W), .TMR_N(TMR_N), .IDX_W(IDX_W)) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (sync_w[p]),
            .sel_idx (idx),
            .tmr_per (tmr_per),
            .resel   (resel[p]),
            .filt    (pin_filt[p])
        );
    end
endmodule

// File: rtl/gdb_checker.sv
module gdb_checker #(
    parameter int PIN_N  = 32,
    parameter int TMR_N  = 3,
    parameter int PER_W  = 32,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [PIN_N-1:0]            pin_raw,
    input logic                        reg_wr,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [DATA_W-1:0]           reg_wdata,
    input logic [DATA_W-1:0]           reg_rdata,
    input logic [PIN_N-1:0]            pin_filt,
    input logic [IDX_W-1:0][PIN_N-1:0] sel_plane,
    input logic [TMR_N-1:0][PER_W-1:0] tmr_per
);
    localparam int LAST_ADR = TMR_N + IDX_W;

    logic [2:0]        age;
    logic [PIN_N-1:0]  filt_on;
    logic [DATA_W-1:0] wr_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age <= '0;
        else if (age != 3'd7)
            age <= age + 3'd1;
    end

    always_comb begin
        filt_on = '0;
        for (int b = 0; b < IDX_W; b++)
            filt_on = filt_on | sel_plane[b];
        for (int i = 0; i < DATA_W; i++)
            wr_mask[i] = (int'(reg_addr) <= TMR_N) ? (i < PER_W) : (i < PIN_N);
    end

    a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != '0 && int'(reg_addr) <= LAST_ADR)
        |=> (reg_addr != $past(reg_addr)) || (reg_rdata == ($past(reg_wdata) & $past(wr_mask))));

    a_r1_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == '0 || int'(reg_addr) > LAST_ADR) |-> reg_rdata == '0);

    a_r8_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3'd0) |-> (sel_plane == '0 && tmr_per == '0 && pin_filt == '0));

    a_r3_bypass_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd3) |-> ((~filt_on & (pin_filt ^ $past(pin_raw, 2))) == '0));

    a_r10_commit_value: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd4) |->
        (((pin_filt ^ $past(pin_filt)) & filt_on & $past(filt_on)
          & (pin_filt ^ $past(pin_raw, 3))) == '0));

    for (genvar p = 0; p < PIN_N; p++) begin : g_pin
        logic [IDX_W-1:0] idx;
        logic             zero_per;
        always_comb begin
            for (int b = 0; b < IDX_W; b++)
                idx[b] = sel_plane[b][p];
            zero_per = 1'b0;
            for (int t = 0; t < TMR_N; t++) begin
                if (idx == IDX_W'(t + 1) && tmr_per[t] == '0)
                    zero_per = 1'b1;
            end
        end

        a_r7_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 3'd4 && $past(zero_per) && idx == $past(idx))
            |-> pin_filt[p] == $past(pin_raw[p], 3));
    end
endmodule

bind gpio_debounce_bank gdb_checker #(
    .PIN_N (PIN_N), .TMR_N (TMR_N), .PER_W (PER_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W (IDX_W)
) u_gdb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_raw   (pin_raw),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_filt  (pin_filt),
    .sel_plane (sel_plane),
    .tmr_per   (tmr_per)
);

// File: tb/gpio_debounce_bank_bench.sv
module gpio_debounce_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_raw = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_filt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    gpio_debounce_bank u_gpio_debounce_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_raw   (pin_raw),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_filt  (pin_filt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lat(input int idx, input longint per);
        if (idx == 0) return 2;
        if (per <= 1) return 3;
        return int'(per) + 2;
    endfunction

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
        @(negedge clk);
    endtask

    // drive a new level on one pin and count rising edges until the output follows
    task automatic measure(input int p, input int exp, input string tag);
        logic v;
        int   n;
        v = ~pin_raw[p];
        pin_raw[p] = v;
        n = 0;
        while (pin_filt[p] != v && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic sweep(input logic [31:0] hi, input logic [31:0] lo,
                         input logic [31:0] p1, input logic [31:0] p2, input logic [31:0] p3);
        longint per;
        wr_reg(3'd1, p1);
        wr_reg(3'd2, p2);
        wr_reg(3'd3, p3);
        wr_reg(3'd4, hi);
        wr_reg(3'd5, lo);
        for (int p = 0; p < 32; p++) begin
            int idx;
            idx = {30'd0, hi[p], lo[p]};
            per = (idx == 1) ? p1 : (idx == 2) ? p2 : (idx == 3) ? p3 : 0;
            // R2 R3 R4 R7: latency per pin from its own index
            measure(p, lat(idx, per), $sformatf("R2/R4 pin%0d idx%0d rise", p, idx));
            @(negedge clk);
            measure(p, lat(idx, per), $sformatf("R2/R4 pin%0d idx%0d fall", p, idx));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset values
        for (int a = 1; a <= 5; a++)
            rd_chk(3'(a), 32'd0, $sformatf("R8 reset reg %0d", a));
        chk(pin_filt == 32'd0, "R8 reset filt", pin_filt, 0);

        // R3: bypass delay of two edges
        pin_raw = 32'hF0F0_1234;
        @(negedge clk);
        chk(pin_filt == 32'd0, "R3 one edge", pin_filt, 0);
        @(negedge clk);
        chk(pin_filt == 32'hF0F0_1234, "R3 two edges", pin_filt, 32'hF0F0_1234);

        // R1: register read-back and unmapped addresses
        wr_reg(3'd1, 32'hDEAD_0001);
        wr_reg(3'd2, 32'h0000_BEEF);
        wr_reg(3'd3, 32'h8000_0003);
        wr_reg(3'd0, 32'hFFFF_FFFF);
        wr_reg(3'd6, 32'hFFFF_FFFF);
        wr_reg(3'd7, 32'hFFFF_FFFF);
        rd_chk(3'd1, 32'hDEAD_0001, "R1 timer1");
        rd_chk(3'd2, 32'h0000_BEEF, "R1 timer2");
        rd_chk(3'd3, 32'h8000_0003, "R1 timer3");
        rd_chk(3'd4, 32'd0, "R1 plane hi untouched");
        rd_chk(3'd5, 32'd0, "R1 plane lo untouched");
        rd_chk(3'd0, 32'd0, "R1 addr0 zero");
        rd_chk(3'd6, 32'd0, "R1 addr6 zero");
        rd_chk(3'd7, 32'd0, "R1 addr7 zero");
        wr_reg(3'd4, 32'h1234_5678);
        wr_reg(3'd5, 32'h9ABC_DEF0);
        rd_chk(3'd4, 32'h1234_5678, "R1 plane hi");
        rd_chk(3'd5, 32'h9ABC_DEF0, "R1 plane lo");
        wr_reg(3'd4, 32'd0);
        wr_reg(3'd5, 32'd0);
        pin_raw = '0;
        repeat (4) @(negedge clk);

        // R2 R3 R4 R7: sweep all pins under two layouts and two period sets
        sweep(32'hCCCC_CCCC, 32'hAAAA_AAAA, 32'd3, 32'd5, 32'd0);
        sweep(32'h0F0F_3C3C, 32'h5A5A_00FF, 32'd1, 32'd9, 32'd2);

        // R7: zero period on timer 1
        wr_reg(3'd4, 32'd0);
        wr_reg(3'd5, 32'h0000_0001);
        wr_reg(3'd1, 32'd0);
        measure(0, 3, "R7 period zero");
        @(negedge clk);

        // R5: short bounces rejected, long one accepted
        wr_reg(3'd1, 32'd8);
        wr_reg(3'd5, 32'h0000_0200);
        for (int g = 1; g <= 7; g++) begin
            logic cur;
            bit   ok;
            cur = pin_raw[9];
            pin_raw[9] = ~cur;
            repeat (g) @(negedge clk);
            pin_raw[9] = cur;
            ok = 1'b1;
            repeat (14) begin
                @(negedge clk);
                if (pin_filt[9] != cur) ok = 1'b0;
            end
            chk(ok, $sformatf("R5 bounce width %0d", g), pin_filt[9], cur);
        end
        measure(9, 10, "R5 full hold");
        @(negedge clk);

        // R6: shared timer, both pins track a period rewrite
        wr_reg(3'd5, 32'd0);
        wr_reg(3'd4, 32'h0010_0008);
        wr_reg(3'd2, 32'd5);
        for (int k = 0; k < 2; k++) begin
            int n3, n20, n, e;
            logic v3, v20;
            e = (k == 0) ? 7 : 12;
            v3 = ~pin_raw[3];
            v20 = ~pin_raw[20];
            pin_raw[3] = v3;
            pin_raw[20] = v20;
            n = 0; n3 = -1; n20 = -1;
            while ((n3 < 0 || n20 < 0) && n < 200) begin
                @(negedge clk);
                n++;
                if (n3 < 0 && pin_filt[3] == v3) n3 = n;
                if (n20 < 0 && pin_filt[20] == v20) n20 = n;
            end
            chk(n3 == e, "R6 shared pin3", n3, e);
            chk(n20 == e, "R6 shared pin20", n20, e);
            @(negedge clk);
            if (k == 0) wr_reg(3'd2, 32'd10);
        end

        // R9: index change restarts the count
        wr_reg(3'd4, 32'd0);
        wr_reg(3'd5, 32'h0000_0020);
        wr_reg(3'd1, 32'd20);
        wr_reg(3'd3, 32'd4);
        begin
            logic v;
            int   n;
            v = ~pin_raw[5];
            pin_raw[5] = v;
            repeat (6) @(negedge clk);
            chk(pin_filt[5] != v, "R9 still settling", pin_filt[5], ~v);
            wr_reg(3'd4, 32'h0000_0020);
            n = 0;
            while (pin_filt[5] != v && n < 200) begin
                @(negedge clk);
                n++;
            end
            chk(n == 4, "R9 restart after reselect", n, 4);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule